// File: doc/BRIEF.md
# Rack Output Fault Response Controller

This block sits between a rack's commanded output word (the output status table) and the physical output drivers, and decides what the drivers see when something goes wrong. Four conditions can trigger a fault response: an output module fault, a broken rack cable, a loss of external field power, and the processor being in a non-running mode (program or disable). While no trigger is present, the driven word follows the commanded word through one register stage.

Two configuration bits shape the response. The first chooses between clearing every output to zero and holding the outputs at the last value they had before the fault. The second chooses whether output module faults are recognised at all. Cable, power and mode faults always act. The processor's own rack uses a second instance of the same block with its own configuration bit.

The controller is a three-state machine:
- ST_RUN: normal operation; outputs follow the command.
- ST_CLEAR: fault present in clear mode; outputs are zero.
- ST_HOLD: fault present in hold mode; outputs are frozen.

It has these named transitions:
- T_TRIP_CLEAR: ST_RUN to ST_CLEAR, taken when a trigger is present and clear is selected.
- T_TRIP_HOLD: ST_RUN to ST_HOLD, taken when a trigger is present and hold is selected.
- T_TO_HOLD and T_TO_CLEAR: ST_CLEAR to ST_HOLD and back, taken when the clear/hold bit changes while the fault persists.
- T_RECOVER: ST_CLEAR or ST_HOLD to ST_RUN, taken when every trigger is gone.

On T_TRIP_CLEAR and T_TRIP_HOLD, the driven word of that moment is captured as the snapshot used for holding.

Top module: `rack_fault_resp`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) drives out_word to all zeros and fault_active to 0, and clears the hold snapshot.
- R2: With no unmasked trigger, out_word after each rising edge equals the cmd_word sampled at that edge, and fault_active is 0.
- R3: Each of cable_break, power_loss and proc_halted alone, when 1, is a trigger regardless of cfg_mod_en.
- R4: mod_fault is a trigger only when cfg_mod_en is 1. When cfg_mod_en is 0, mod_fault has no effect on out_word or fault_active.
- R5: When cfg_clear is 1 and a trigger is present at an edge, out_word is all zeros after that edge.
- R6: When cfg_clear is 0 and a trigger is present at an edge, out_word after that edge equals the value out_word had before the fault began, whatever cmd_word does.
- R7: At the first edge at which no trigger is present, out_word takes that edge's cmd_word and fault_active returns to 0.
- R8: fault_active is 1 after every edge at which an unmasked trigger is present.
- R9: If cfg_clear changes while a fault persists, out_word switches between zero (cfg_clear=1) and the snapshot taken when the fault began (cfg_clear=0).
- R10: A fault in hold mode that begins right after reset holds all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_word | input | WIDTH | Commanded output word from the status table |
| cfg_clear | input | 1 | 1 = clear outputs on a fault, 0 = hold them |
| cfg_mod_en | input | 1 | 1 = recognise output module faults, 0 = ignore them |
| mod_fault | input | 1 | Output module fault indication |
| cable_break | input | 1 | Rack cable disconnected |
| power_loss | input | 1 | External output power lost |
| proc_halted | input | 1 | Processor in program or disable mode |
| out_word | output | WIDTH | Word driven to the physical outputs |
| fault_active | output | 1 | High while a fault response is in force |

## Verification
Both out_word and fault_active are registered, so each result is due exactly one rising edge after the inputs that cause it. The bench changes inputs on the falling edge and compares outputs on the following falling edge, which is one full edge after the stimulus and before the next change. The vector table is ordered so that each row's expected value follows from the rows before it, including the snapshot taken when a fault starts. Reset is checked at the same one-edge distance, both at start-up and in the middle of a fault.

// File: rtl/rack_fault_resp_pkg.sv
package rack_fault_resp_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CLEAR = 2'd1,
        ST_HOLD  = 2'd2
    } resp_state_e;

endpackage

// File: rtl/rack_fault_trigger.sv
module rack_fault_trigger #(
    parameter int N_HARD = 3
) (
    input  logic [N_HARD-1:0] hard_src,
    input  logic              mod_fault,
    input  logic              cfg_mod_en,
    output logic              trig
);
    logic hard_any;

    assign hard_any = |hard_src;

    // R3: hard sources always act; R4: module fault gated by its enable
    assign trig = hard_any | (mod_fault & cfg_mod_en);

endmodule

// File: rtl/rack_fault_fsm.sv
module rack_fault_fsm
    import rack_fault_resp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        trig,
    input  logic        cfg_clear,
    output resp_state_e state_q,
    output resp_state_e state_d
);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (trig) state_d = cfg_clear ? ST_CLEAR : ST_HOLD;   // T_TRIP_*
            end
            ST_CLEAR: begin
                if (!trig)           state_d = ST_RUN;                // T_RECOVER
                else if (!cfg_clear) state_d = ST_HOLD;               // T_TO_HOLD
            end
            ST_HOLD: begin
                if (!trig)          state_d = ST_RUN;                 // T_RECOVER
                else if (cfg_clear) state_d = ST_CLEAR;               // T_TO_CLEAR
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // R9: while a fault persists the state tracks the clear/hold selection
    a_r9_follow_cfg: assert property (@(posedge clk) disable iff (rst)
        trig |=> (state_q == ($past(cfg_clear) ? ST_CLEAR : ST_HOLD)));

    // R7: no trigger always returns the machine to running
    a_r7_recover: assert property (@(posedge clk) disable iff (rst)
        !trig |=> (state_q == ST_RUN));

endmodule

// File: rtl/rack_fault_outreg.sv
module rack_fault_outreg
    import rack_fault_resp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  resp_state_e      state_q,
    input  resp_state_e      state_d,
    input  logic [WIDTH-1:0] cmd_word,
    output logic [WIDTH-1:0] out_word
);
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] held_q;
    logic             tripping;

    assign tripping = (state_q == ST_RUN) && (state_d != ST_RUN);

    // Snapshot of the last good word, taken when a fault starts
    always_ff @(posedge clk) begin
        if (rst)           held_q <= '0;
        else if (tripping) held_q <= out_q;
    end

    // Driven word selected by the upcoming state
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            unique case (state_d)
                ST_RUN:   out_q <= cmd_word;
                ST_CLEAR: out_q <= '0;
                ST_HOLD:  out_q <= (state_q == ST_RUN) ? out_q : held_q;
                default:  out_q <= '0;
            endcase
        end
    end

    assign out_word = out_q;

    // R9: holding after a clear phase restores the snapshot
    a_r9_restore: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLEAR && state_d == ST_HOLD) |=> (out_q == $past(held_q)));

endmodule

// File: rtl/rack_fault_resp.sv
module rack_fault_resp
    import rack_fault_resp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cmd_word,
    input  logic             cfg_clear,
    input  logic             cfg_mod_en,
    input  logic             mod_fault,
    input  logic             cable_break,
    input  logic             power_loss,
    input  logic             proc_halted,
    output logic [WIDTH-1:0] out_word,
    output logic             fault_active
);
    localparam int N_HARD = 3;

    logic              trig;
    logic [N_HARD-1:0] hard_src;
    resp_state_e       state_q;
    resp_state_e       state_d;

    assign hard_src = {cable_break, power_loss, proc_halted};

    rack_fault_trigger #(.N_HARD(N_HARD)) u_trig (
        .hard_src   (hard_src),
        .mod_fault  (mod_fault),
        .cfg_mod_en (cfg_mod_en),
        .trig       (trig)
    );

    rack_fault_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .cfg_clear (cfg_clear),
        .state_q   (state_q),
        .state_d   (state_d)
    );

    rack_fault_outreg #(.WIDTH(WIDTH)) u_out (
        .clk      (clk),
        .rst      (rst),
        .state_q  (state_q),
        .state_d  (state_d),
        .cmd_word (cmd_word),
        .out_word (out_word)
    );

    assign fault_active = (state_q != ST_RUN);

    // R1: reset clears the outputs and the flag
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (out_word == '0 && !fault_active));

    // R2 / R7: without a trigger the command passes with one edge of delay
    a_r2_follow: assert property (@(posedge clk) disable iff (rst)
        (!cable_break && !power_loss && !proc_halted && !(mod_fault && cfg_mod_en))
        |=> (out_word == $past(cmd_word) && !fault_active));

    // R4: a masked module fault alone never raises the flag
    a_r4_masked: assert property (@(posedge clk) disable iff (rst)
        (mod_fault && !cfg_mod_en && !cable_break && !power_loss && !proc_halted)
        |=> !fault_active);

    // R5: clear mode zeroes the outputs
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (trig && cfg_clear) |=> (out_word == '0));

    // R6: hold mode freezes the outputs unless leaving a clear phase
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (trig && !cfg_clear && state_q != ST_CLEAR) |=> $stable(out_word));

    // R8: any unmasked trigger raises the flag
    a_r8_flag: assert property (@(posedge clk) disable iff (rst)
        (cable_break || power_loss || proc_halted || (mod_fault && cfg_mod_en))
        |=> fault_active);

endmodule

// File: tb/rack_fault_resp_test.sv
module rack_fault_resp_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cmd_word = '0;
    logic         cfg_clear = 1'b1, cfg_mod_en = 1'b0;
    logic         mod_fault = 1'b0, cable_break = 1'b0, power_loss = 1'b0, proc_halted = 1'b0;
    logic [W-1:0] out_word;
    logic         fault_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rack_fault_resp #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .cmd_word(cmd_word), .cfg_clear(cfg_clear),
        .cfg_mod_en(cfg_mod_en), .mod_fault(mod_fault), .cable_break(cable_break),
        .power_loss(power_loss), .proc_halted(proc_halted),
        .out_word(out_word), .fault_active(fault_active)
    );

    // {cable, power, halted, mod, mod_en, clear, cmd[16], exp_out[16], exp_flag}
    localparam int NV = 16;
    localparam logic [38:0] VEC [NV] = '{
        {6'b000001, 16'h1234, 16'h1234, 1'b0},  // R2
        {6'b000001, 16'hABCD, 16'hABCD, 1'b0},  // R2
        {6'b100001, 16'h1111, 16'h0000, 1'b1},  // R3 cable, R5
        {6'b100001, 16'h2222, 16'h0000, 1'b1},  // R5
        {6'b000001, 16'h3333, 16'h3333, 1'b0},  // R7
        {6'b010000, 16'h4444, 16'h3333, 1'b1},  // R3 power, R6
        {6'b010000, 16'h5555, 16'h3333, 1'b1},  // R6
        {6'b000000, 16'h5555, 16'h5555, 1'b0},  // R7
        {6'b000101, 16'h6666, 16'h6666, 1'b0},  // R4 masked
        {6'b000111, 16'h7777, 16'h0000, 1'b1},  // R4 recognised, R8
        {6'b001000, 16'h8888, 16'h6666, 1'b1},  // R9 to hold: snapshot
        {6'b001001, 16'h8888, 16'h0000, 1'b1},  // R9 to clear
        {6'b001000, 16'h9999, 16'h6666, 1'b1},  // R9 back to hold
        {6'b000000, 16'h0F0F, 16'h0F0F, 1'b0},  // R7
        {6'b001000, 16'h0001, 16'h0F0F, 1'b1},  // R3 halted, R6
        {6'b000000, 16'hFFFF, 16'hFFFF, 1'b0}   // R7
    };

    task automatic check(input string req, input logic [W-1:0] exp_o, input logic exp_f);
        checks++;
        if (out_word !== exp_o || fault_active !== exp_f) begin
            errors++;
            $display("FAIL %s: out_word=%h fault_active=%b expected out_word=%h fault_active=%b",
                     req, out_word, fault_active, exp_o, exp_f);
        end
    endtask

    task automatic apply(input logic [5:0] c, input logic [W-1:0] cmd);
        {cable_break, power_loss, proc_halted, mod_fault, cfg_mod_en, cfg_clear} = c;
        cmd_word = cmd;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1 reset", 16'h0000, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][38:33], VEC[i][32:17]);
            @(negedge clk);
            check($sformatf("R2-R9 vector %0d", i), VEC[i][16:1], VEC[i][0]);
        end

        // Hold fault with a non-zero word, then reset in the middle of it
        apply(6'b010000, 16'h1357);
        @(negedge clk);
        check("R6 hold FFFF", 16'hFFFF, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset during fault", 16'h0000, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 hold after reset", 16'h0000, 1'b1);
        @(negedge clk);
        check("R10 hold stays zero", 16'h0000, 1'b1);
        apply(6'b000000, 16'h2468);
        @(negedge clk);
        check("R7 resume after reset fault", 16'h2468, 1'b0);

        // Masked module fault with changing command has no effect
        apply(6'b000100, 16'hC0DE);
        @(negedge clk);
        check("R4 masked follow", 16'hC0DE, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule